// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block connects an 8-bit processor bus with a 16-bit address space to one 512K x 8 static RAM. It holds a write-only control byte, loaded by an I/O write to port 0xFF, and it forms the RAM's 19-bit address and its active-low strobes from the processor's address and that byte. The lower half of the processor map, 0x0000 to 0x7FFF, is fixed to RAM page 0. The upper half, 0x8000 to 0xFFFF, shows one of pages 1 to 15, selected by the low nibble of the control byte. A nibble of zero is read as page 1, so after reset the processor sees the first 64K of RAM as one unbroken space.

Two other bits of the control byte are passed out: one enables a 2K video memory overlay and one selects the text width. While the overlay is on, the RAM stays silent in the video window so that the video memory can answer there. A two-bit configuration input mutes the RAM in page 14 and page 15 on their own. This lets a second board that owns those pages share the bus.

Top module: `bank_mapper`

## Requirements
- R1: While reset is asserted, and after it until the first port write, the control byte is zero. So mode_4080 and video_en are 0, and an upper-half access goes to page 1 (ram_addr = 0x08000 for CPU 0x8000).
- R2: On a rising clock edge where iorq_n and wr_n are both low and cpu_addr[7:0] equals 0xFF, the control byte takes cpu_data. An I/O write to any other port, or a memory write, leaves it unchanged.
- R3: For CPU addresses with bit 15 clear, ram_addr[18:15] is 0 and ram_addr[14:0] equals cpu_addr[14:0], whatever the control byte holds.
- R4: For CPU addresses with bit 15 set, ram_addr[14:0] equals cpu_addr[14:0]. ram_addr[18:15] equals control bits 3:0, except that the value 0 gives page 1.
- R5: mode_4080 follows control bit 4, and video_en follows control bit 7.
- R6: While control bit 7 is set, ram_ce_n stays high for CPU addresses 0xF800 to 0xFFFF. While it is clear, the RAM answers there as usual.
- R7: hi_page_disable[0] holds ram_ce_n high for upper-half accesses that map to page 14, and hi_page_disable[1] does the same for page 15. Lower-half accesses and other pages are not affected.
- R8: ram_ce_n is low only when mreq_n is low, one of rd_n or wr_n is low, and no R6 or R7 block applies. ram_oe_n is low only on such a read, and ram_we_n only on such a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the control byte is loaded on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address; bits 7:0 also carry the I/O port number |
| cpu_data | input | 8 | Processor write data |
| iorq_n | input | 1 | Active-low I/O request |
| mreq_n | input | 1 | Active-low memory request |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| hi_page_disable | input | 2 | Bit 0 mutes page 14, bit 1 mutes page 15 |
| ram_addr | output | 19 | RAM address: page in bits 18:15, offset in bits 14:0 |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| mode_4080 | output | 1 | Text-width mode bit from the control byte |
| video_en | output | 1 | Video overlay enable from the control byte |

## Verification
The strobe assertions take for granted that the processor never drives rd_n and wr_n low together. They also take for granted that the address, data and request lines are steady at each rising clock edge. The bench keeps to both: it changes inputs only on falling edges, and each access pulls down exactly one strobe. The video-window assertion also takes for granted that the window lies inside the upper half, which the default parameters meet.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int CTRL_W = 8;

  // Control byte: bit 7 video overlay, bits 6:5 spare, bit 4 width, bits 3:0 page
  typedef struct packed {
    logic       vid;
    logic [1:0] spare;
    logic       wide;
    logic [3:0] page;
  } ctrl_t;
endpackage

// File: rtl/bm_rst_sync.sv
module bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb begin
    sync_nxt = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_nxt;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bm_ctrl_latch.sv
module bm_ctrl_latch
  import bank_mapper_pkg::*;
#(
  parameter int            IO_AW   = 8,
  parameter logic [IO_AW-1:0] IO_PORT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic [CTRL_W-1:0] io_data,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic [3:0]        page_nib,
  output logic              wide,
  output logic              vid
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_nxt;
  logic  load_en;

  assign load_en = !iorq_n && !wr_n && (io_addr == IO_PORT);

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (load_en) ctrl_nxt = ctrl_t'(io_data);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_nxt;
  end

  assign page_nib = ctrl_q.page;
  assign wide     = ctrl_q.wide;
  assign vid      = ctrl_q.vid;

  // R2: a port write lands in the byte one edge later
  p_port_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (CTRL_W'(ctrl_q) == $past(io_data)));

  // R2: any other cycle keeps the byte
  p_port_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ctrl_q));

  // R1: the byte comes out of reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (CTRL_W'(ctrl_q) == '0));
endmodule

// File: rtl/bm_addr_xlate.sv
module bm_addr_xlate #(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int NUM_HI   = 2,
  parameter int VID_BASE = 16'hF800,
  parameter int VID_SIZE = 2048,
  localparam int OFF_W   = ADDR_W - 1,
  localparam int RAM_AW  = OFF_W + PAGE_W,
  localparam int NPAGE   = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [PAGE_W-1:0] page_nib,
  input  logic              vid_on,
  input  logic [NUM_HI-1:0] hi_page_disable,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n
);
  localparam logic [ADDR_W:0] VID_LO = (ADDR_W+1)'(VID_BASE);
  localparam logic [ADDR_W:0] VID_HI = (ADDR_W+1)'(VID_BASE + VID_SIZE);

  logic              upper;
  logic [PAGE_W-1:0] page_eff;
  logic [PAGE_W-1:0] page_sel;
  logic              vid_hit;
  logic [NUM_HI-1:0] hi_blk;
  logic              blocked;
  logic              access;

  assign upper    = cpu_addr[ADDR_W-1];
  assign page_eff = (page_nib == '0) ? PAGE_W'(1) : page_nib;
  assign page_sel = upper ? page_eff : '0;
  assign ram_addr = {page_sel, cpu_addr[OFF_W-1:0]};

  assign vid_hit = vid_on && ({1'b0, cpu_addr} >= VID_LO) && ({1'b0, cpu_addr} < VID_HI);

  for (genvar i = 0; i < NUM_HI; i++) begin : g_hi
    localparam logic [PAGE_W-1:0] PG = PAGE_W'(NPAGE - NUM_HI + i);
    assign hi_blk[i] = hi_page_disable[i] && upper && (page_eff == PG);
  end

  assign blocked  = vid_hit || (|hi_blk);
  assign access   = !mreq_n && (!rd_n || !wr_n);
  assign ram_ce_n = !(access && !blocked);
  assign ram_oe_n = ram_ce_n || rd_n;
  assign ram_we_n = ram_ce_n || wr_n;

  // R3: lower half is pinned to page 0 with the offset passed through
  p_low_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[ADDR_W-1] |-> (ram_addr == RAM_AW'(cpu_addr[OFF_W-1:0])));

  // R4: upper half never lands on page 0
  p_upper_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_addr[ADDR_W-1] |-> (ram_addr[RAM_AW-1:OFF_W] != '0));

  // R6: overlay window keeps the RAM quiet
  p_video_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vid_on && ({1'b0, cpu_addr} >= VID_LO) && ({1'b0, cpu_addr} < VID_HI)) |-> ram_ce_n);

  // R7: top page muted when its disable bit is set
  p_top_page_mute_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_page_disable[NUM_HI-1] && (ram_addr[RAM_AW-1:OFF_W] == PAGE_W'(NPAGE-1))) |-> ram_ce_n);

  // R8: no strobe without a memory request
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (ram_ce_n && ram_oe_n && ram_we_n));

  // R8: at most one of the read and write strobes
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!ram_oe_n, !ram_we_n}) <= 1);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 4,
  parameter int NUM_HI   = 2,
  parameter int VID_BASE = 16'hF800,
  parameter int VID_SIZE = 2048,
  parameter int IO_AW    = 8,
  parameter int IO_PORT  = 8'hFF,
  localparam int RAM_AW  = ADDR_W - 1 + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CTRL_W-1:0] cpu_data,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [NUM_HI-1:0] hi_page_disable,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic              mode_4080,
  output logic              video_en
);
  logic       srst_n;
  logic [3:0] page_nib;

  bm_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bm_ctrl_latch #(.IO_AW(IO_AW), .IO_PORT(IO_AW'(IO_PORT))) u_latch (
    .clk      (clk),
    .rst_n    (srst_n),
    .io_addr  (cpu_addr[IO_AW-1:0]),
    .io_data  (cpu_data),
    .iorq_n   (iorq_n),
    .wr_n     (wr_n),
    .page_nib (page_nib),
    .wide     (mode_4080),
    .vid      (video_en)
  );

  bm_addr_xlate #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .NUM_HI(NUM_HI),
    .VID_BASE(VID_BASE), .VID_SIZE(VID_SIZE)
  ) u_xlate (
    .clk             (clk),
    .rst_n           (srst_n),
    .cpu_addr        (cpu_addr),
    .mreq_n          (mreq_n),
    .rd_n            (rd_n),
    .wr_n            (wr_n),
    .page_nib        (PAGE_W'(page_nib)),
    .vid_on          (video_en),
    .hi_page_disable (hi_page_disable),
    .ram_addr        (ram_addr),
    .ram_ce_n        (ram_ce_n),
    .ram_oe_n        (ram_oe_n),
    .ram_we_n        (ram_we_n)
  );
endmodule

// File: tb/tb_bank_mapper.sv
`timescale 1ns/1ps
module tb_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_data;
  logic        iorq_n, mreq_n, rd_n, wr_n;
  logic [1:0]  hi_page_disable;
  logic [18:0] ram_addr;
  logic        ram_ce_n, ram_oe_n, ram_we_n, mode_4080, video_en;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] shadow;

  always #2.5 clk = ~clk;

  bank_mapper dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_page_disable(hi_page_disable), .ram_addr(ram_addr),
    .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .mode_4080(mode_4080), .video_en(video_en)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    iorq_n = 1'b1; mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_write(input logic [7:0] port, input logic [7:0] data);
    @(negedge clk);
    cpu_addr = {8'h00, port}; cpu_data = data; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    idle();
    if (port == 8'hFF) shadow = data;
  endtask

  // Expected RAM response for one access, from the shadow byte
  task automatic mem_access(input logic [15:0] a, input bit is_wr, input string req);
    logic [3:0]  pg;
    logic [18:0] ea;
    bit          blk;
    @(negedge clk);
    cpu_addr = a; mreq_n = 1'b0;
    if (is_wr) wr_n = 1'b0; else rd_n = 1'b0;
    #1;
    pg  = a[15] ? ((shadow[3:0] == 4'd0) ? 4'd1 : shadow[3:0]) : 4'd0;
    ea  = {pg, a[14:0]};
    blk = (shadow[7] && a >= 16'hF800) ||
          (a[15] && pg == 4'd14 && hi_page_disable[0]) ||
          (a[15] && pg == 4'd15 && hi_page_disable[1]);
    check(ram_addr == ea, req, 32'(ram_addr), 32'(ea));
    check(ram_ce_n == blk, req, 32'(ram_ce_n), 32'(blk));
    check(ram_oe_n == (blk || is_wr), "R8", 32'(ram_oe_n), 32'(blk || is_wr));
    check(ram_we_n == (blk || !is_wr), "R8", 32'(ram_we_n), 32'(blk || !is_wr));
    idle();
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [15:0] pts [8];
    pts = '{16'h0000, 16'h1234, 16'h7FFF, 16'h8000, 16'hC0DE, 16'hF7FF, 16'hF800, 16'hFFFF};
    shadow = 8'h00;
    idle();
    cpu_addr = 16'h0000; cpu_data = 8'h00; hi_page_disable = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mode_4080 == 1'b0, "R1", 32'(mode_4080), 0);
    check(video_en == 1'b0, "R1", 32'(video_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mem_access(16'h8000, 1'b0, "R1");
    check(ram_addr == 19'h08000, "R1", 32'(ram_addr), 32'h08000);

    // R3 R4 R6 R7: sweep of page nibble, overlay, width and disables
    for (int hp = 0; hp < 4; hp++) begin
      hi_page_disable = 2'(hp);
      for (int nib = 0; nib < 16; nib++) begin
        for (int vw = 0; vw < 4; vw++) begin
          logic [7:0] b;
          b = {vw[1], 2'b00, vw[0], 4'(nib)};
          io_write(8'hFF, b);
          #1;
          check(mode_4080 == b[4], "R5", 32'(mode_4080), 32'(b[4]));
          check(video_en == b[7], "R5", 32'(video_en), 32'(b[7]));
          for (int k = 0; k < 8; k++) begin
            mem_access(pts[k], k[0], pts[k][15] ? (pts[k] >= 16'hF800 ? "R6" : (hp != 0 ? "R7" : "R4")) : "R3");
          end
        end
      end
    end

    // R2: writes elsewhere are ignored
    hi_page_disable = 2'b00;
    io_write(8'hFF, 8'h95);
    io_write(8'hFE, 8'h07);
    #1;
    check(mode_4080 == 1'b1 && video_en == 1'b1, "R2", {mode_4080, video_en}, 2'b11);
    mem_access(16'h9000, 1'b0, "R2");
    @(negedge clk);
    cpu_addr = 16'h00FF; cpu_data = 8'h0A; mreq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    idle();
    mem_access(16'h9000, 1'b0, "R2");
    check(ram_addr[18:15] == 4'd5, "R2", 32'(ram_addr[18:15]), 5);
    io_write(8'hFF, 8'h0C);
    mem_access(16'hA000, 1'b1, "R2");
    check(ram_addr[18:15] == 4'd12 && mode_4080 == 1'b0, "R2", 32'(ram_addr[18:15]), 12);

    // R8: no request, or request without strobe, keeps the RAM off
    @(negedge clk);
    cpu_addr = 16'h4000; rd_n = 1'b0; #1;
    check(ram_ce_n && ram_oe_n, "R8", {ram_ce_n, ram_oe_n}, 2'b11);
    rd_n = 1'b1; mreq_n = 1'b0; #1;
    check(ram_ce_n && ram_oe_n && ram_we_n, "R8", {ram_ce_n, ram_oe_n, ram_we_n}, 3'b111);
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule